// File: doc/BRIEF.md
# Mixed-Width Dual-Port Block RAM

This block is a simple dual-port memory holding 4,608 bits. It has one write port and one read port. Each port has its own clock, enable, address and data. Each port also has its own shape code, which picks one of five aspect ratios: 4k×1, 2k×2, 1k×4, 512×9 or 256×18. Both ports share one storage array, so data written at one width can be read back at any other. The address of each port is decoded according to that port's shape. Address bits above the range of the selected shape are ignored.

The storage is organised as 512 nine-bit lanes. Each lane holds eight data bits and one extra bit. Taken together, the data bits form a 4,096-bit data space. The 4-, 2- and 1-bit shapes reach only that data space. The 9-bit and 18-bit shapes also reach the 512 extra bits.

Shape codes are configuration inputs. They are expected to stay stable while the matching enable is in use. Codes 5 to 7 are reserved and decode like code 0. The read output register has an asynchronous active-low reset. The storage array has no reset.

Top module: `mwr_ram`

## Requirements
- R1: Shape codes apply to both ports and select the word shape: 0 = 4096×1, 1 = 2048×2, 2 = 1024×4, 3 = 512×9, 4 = 256×18. The two ports may use different codes at the same time.
- R2: In the 1-, 2- and 4-bit shapes (w = 1, 2, 4), word k occupies data bits k·w to k·w+w−1 of the 4,096-bit data space, least significant bit first. Such a write leaves every other data bit and every extra bit unchanged.
- R3: In the 9-bit shape, word k carries data bits 8k to 8k+7 in bits [7:0] and extra bit k in bit [8].
- R4: In the 18-bit shape, word k carries 9-bit word 2k in bits [8:0] and 9-bit word 2k+1 in bits [17:9].
- R5: Data written in any shape reads back through any read shape according to the mappings of R2 to R4. For example, a 4-bit write can be read as a 1-bit stream.
- R6: With the read enable high at a rising read-clock edge, the word at the read address appears on the read data output after that edge, and not before it.
- R7: With the read enable low at a read-clock edge, the read data output keeps its previous value.
- R8: With the write enable low at a write-clock edge, no stored bit changes, whatever the write address and data are.
- R9: When a read and a write to the same location happen at the same edge of a shared clock, the read returns the contents from before the write.
- R10: Read data bits above the width of the read shape are zero. Address bits above the range of the selected shape are ignored, so word k is reached from any address congruent to k modulo the shape's depth.
- R11: While the read reset is low, the read data output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write port clock |
| wen | input | 1 | Write enable, active high |
| wr_shape | input | 3 | Write shape code (0 = ×1, 1 = ×2, 2 = ×4, 3 = ×9, 4 = ×18) |
| waddr | input | 12 | Write word address |
| wdata | input | 18 | Write data, right-aligned to the write shape |
| rclk | input | 1 | Read port clock |
| rrst_n | input | 1 | Asynchronous active-low reset of the read data register |
| ren | input | 1 | Read enable, active high |
| rd_shape | input | 3 | Read shape code, same encoding as wr_shape |
| raddr | input | 12 | Read word address |
| rdata | output | 18 | Registered read data, right-aligned and zero-extended |

## Verification
A read presented with the enable high is due one read-clock edge later. The bench drives every input at a falling edge and compares the read output at the next falling edge, half a cycle after the rising edge that loaded it. A write lands at the rising edge where it is presented. The bench's model therefore computes the expected read word from the old contents first, and only then applies the write of the same cycle. This ordering is what makes a same-address collision return old data. Shape codes change only in cycles where both enables are low, so each word is compared against the shape that was in force when it was read.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

    typedef enum logic [2:0] {
        SHP_X1  = 3'd0,
        SHP_X2  = 3'd1,
        SHP_X4  = 3'd2,
        SHP_X9  = 3'd3,
        SHP_X18 = 3'd4
    } shape_e;

    localparam int LANE_W = 9;   // eight data bits plus one extra bit

endpackage

// File: rtl/mwr_wr_lane.sv
// Write-side decode: turns a shaped address and data word into masked
// updates of one or two nine-bit storage lanes.
module mwr_wr_lane
    import mwr_pkg::*;
#(
    parameter int IDX_W  = 9,
    parameter int DATA_W = 18,
    localparam int ADDR_W = IDX_W + 3
) (
    input  logic [2:0]        shape,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic [IDX_W-1:0]  lo_idx,
    output logic [IDX_W-1:0]  hi_idx,
    output logic [LANE_W-1:0] lo_mask,
    output logic [LANE_W-1:0] hi_mask,
    output logic [LANE_W-1:0] lo_bits,
    output logic [LANE_W-1:0] hi_bits,
    output logic              hi_en
);

    logic [2:0] off;

    always_comb begin
        off     = '0;
        lo_idx  = addr[ADDR_W-1:3];
        hi_idx  = addr[ADDR_W-1:3];
        lo_mask = '0;
        hi_mask = '0;
        lo_bits = '0;
        hi_bits = '0;
        hi_en   = 1'b0;
        case (shape)
            SHP_X2: begin
                lo_idx  = addr[IDX_W+1:2];
                hi_idx  = lo_idx;
                off     = {addr[1:0], 1'b0};
                lo_mask = 9'h003 << off;
                lo_bits = {7'b0, data[1:0]} << off;
            end
            SHP_X4: begin
                lo_idx  = addr[IDX_W:1];
                hi_idx  = lo_idx;
                off     = {addr[0], 2'b00};
                lo_mask = 9'h00F << off;
                lo_bits = {5'b0, data[3:0]} << off;
            end
            SHP_X9: begin
                lo_idx  = addr[IDX_W-1:0];
                hi_idx  = lo_idx;
                lo_mask = '1;
                lo_bits = data[LANE_W-1:0];
            end
            SHP_X18: begin
                lo_idx  = {addr[IDX_W-2:0], 1'b0};
                hi_idx  = {addr[IDX_W-2:0], 1'b1};
                lo_mask = '1;
                hi_mask = '1;
                lo_bits = data[LANE_W-1:0];
                hi_bits = data[2*LANE_W-1:LANE_W];
                hi_en   = 1'b1;
            end
            default: begin          // SHP_X1 and reserved codes
                lo_idx  = addr[ADDR_W-1:3];
                hi_idx  = lo_idx;
                off     = addr[2:0];
                lo_mask = 9'h001 << off;
                lo_bits = {8'b0, data[0]} << off;
            end
        endcase
    end

endmodule

// File: rtl/mwr_rd_lane.sv
// Read-side decode: picks the lanes for a shaped address and aligns the
// selected bits into a right-justified, zero-extended word.
module mwr_rd_lane
    import mwr_pkg::*;
#(
    parameter int IDX_W  = 9,
    parameter int DATA_W = 18,
    localparam int ADDR_W = IDX_W + 3
) (
    input  logic [2:0]        shape,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] lo_lane,
    input  logic [LANE_W-1:0] hi_lane,
    output logic [IDX_W-1:0]  lo_idx,
    output logic [IDX_W-1:0]  hi_idx,
    output logic [DATA_W-1:0] word
);

    logic [2:0]        off;
    logic [LANE_W-1:0] shifted;

    always_comb begin
        off    = '0;
        lo_idx = addr[ADDR_W-1:3];
        hi_idx = lo_idx;
        case (shape)
            SHP_X2:  begin lo_idx = addr[IDX_W+1:2]; off = {addr[1:0], 1'b0}; end
            SHP_X4:  begin lo_idx = addr[IDX_W:1];   off = {addr[0], 2'b00};  end
            SHP_X9:  lo_idx = addr[IDX_W-1:0];
            SHP_X18: begin
                lo_idx = {addr[IDX_W-2:0], 1'b0};
                hi_idx = {addr[IDX_W-2:0], 1'b1};
            end
            default: begin lo_idx = addr[ADDR_W-1:3]; off = addr[2:0]; end
        endcase
        if (shape != SHP_X18) hi_idx = lo_idx;
    end

    always_comb begin
        shifted = lo_lane >> off;
        word    = '0;
        case (shape)
            SHP_X2:  word[1:0]        = shifted[1:0];
            SHP_X4:  word[3:0]        = shifted[3:0];
            SHP_X9:  word[LANE_W-1:0] = lo_lane;
            SHP_X18: word             = {hi_lane, lo_lane};
            default: word[0]          = shifted[0];
        endcase
    end

endmodule

// File: rtl/mwr_ram.sv
// Mixed-width simple dual-port RAM: 512 lanes of nine bits, one write port
// and one registered read port, each with its own shape code.
module mwr_ram
    import mwr_pkg::*;
#(
    parameter int LANES  = 512,
    parameter int DATA_W = 2 * LANE_W,
    localparam int IDX_W  = $clog2(LANES),
    localparam int ADDR_W = IDX_W + 3
) (
    input  logic              wclk,
    input  logic              wen,
    input  logic [2:0]        wr_shape,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              ren,
    input  logic [2:0]        rd_shape,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [LANE_W-1:0] mem [LANES];

    logic [IDX_W-1:0]  w_lo_idx, w_hi_idx;
    logic [LANE_W-1:0] w_lo_mask, w_hi_mask, w_lo_bits, w_hi_bits;
    logic              w_hi_en;

    logic [IDX_W-1:0]  r_lo_idx, r_hi_idx;
    logic [DATA_W-1:0] r_word;

    mwr_wr_lane #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_wr (
        .shape   (wr_shape),
        .addr    (waddr),
        .data    (wdata),
        .lo_idx  (w_lo_idx),
        .hi_idx  (w_hi_idx),
        .lo_mask (w_lo_mask),
        .hi_mask (w_hi_mask),
        .lo_bits (w_lo_bits),
        .hi_bits (w_hi_bits),
        .hi_en   (w_hi_en)
    );

    mwr_rd_lane #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd (
        .shape   (rd_shape),
        .addr    (raddr),
        .lo_lane (mem[r_lo_idx]),
        .hi_lane (mem[r_hi_idx]),
        .lo_idx  (r_lo_idx),
        .hi_idx  (r_hi_idx),
        .word    (r_word)
    );

    // Write port: masked lane updates; R8 when wen is low nothing changes.
    always_ff @(posedge wclk) begin
        if (wen) begin
            mem[w_lo_idx] <= (mem[w_lo_idx] & ~w_lo_mask) | (w_lo_bits & w_lo_mask);
            if (w_hi_en)
                mem[w_hi_idx] <= (mem[w_hi_idx] & ~w_hi_mask) | (w_hi_bits & w_hi_mask);
        end
    end

    // Read port: registered output, holds while ren is low (R6, R7, R11).
    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n)
            rdata <= '0;
        else if (ren)
            rdata <= r_word;
    end

endmodule

// File: rtl/mwr_ram_chk.sv
module mwr_ram_chk
    import mwr_pkg::*;
#(
    parameter int IDX_W  = 9,
    parameter int DATA_W = 18
) (
    input logic              wclk,
    input logic              rclk,
    input logic              rrst_n,
    input logic              wen,
    input logic              ren,
    input logic [2:0]        wr_shape,
    input logic [2:0]        rd_shape,
    input logic [IDX_W-1:0]  w_lo_idx,
    input logic [IDX_W-1:0]  w_hi_idx,
    input logic [LANE_W-1:0] w_lo_mask,
    input logic              w_hi_en,
    input logic [DATA_W-1:0] rdata
);

    // R2: narrow writes touch exactly w bits of a single lane
    a_r2_narrow_one_lane: assert property (@(posedge wclk) disable iff (!rrst_n)
        (wen && wr_shape <= 3'd2) |->
            (!w_hi_en && $countones(w_lo_mask) == (1 << wr_shape)));

    // R3: nine-bit writes cover one whole lane
    a_r3_nine_full_lane: assert property (@(posedge wclk) disable iff (!rrst_n)
        (wen && wr_shape == SHP_X9) |-> (&w_lo_mask && !w_hi_en));

    // R4: eighteen-bit writes hit an even lane and its odd neighbour
    a_r4_wide_lane_pair: assert property (@(posedge wclk) disable iff (!rrst_n)
        (wen && wr_shape == SHP_X18) |->
            (w_hi_en && !w_lo_idx[0] && w_hi_idx == w_lo_idx + 1'b1));

    // R7: output holds while read enable is low
    a_r7_hold_output: assert property (@(posedge rclk) disable iff (!rrst_n)
        !ren |=> $stable(rdata));

    // R10: bits above a narrow read width are zero
    a_r10_narrow_upper_zero: assert property (@(posedge rclk) disable iff (!rrst_n)
        (ren && rd_shape == SHP_X4) |=> (rdata[DATA_W-1:4] == '0));

    // R10: bits above the nine-bit read width are zero
    a_r10_nine_upper_zero: assert property (@(posedge rclk) disable iff (!rrst_n)
        (ren && rd_shape == SHP_X9) |=> (rdata[DATA_W-1:LANE_W] == '0));

    // R11: output is zero while reset is low
    always @(negedge rclk) begin
        if (!rrst_n) begin
            a_r11_reset_zero: assert (rdata == '0);
        end
    end

endmodule

bind mwr_ram mwr_ram_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
    .wclk      (wclk),
    .rclk      (rclk),
    .rrst_n    (rrst_n),
    .wen       (wen),
    .ren       (ren),
    .wr_shape  (wr_shape),
    .rd_shape  (rd_shape),
    .w_lo_idx  (w_lo_idx),
    .w_hi_idx  (w_hi_idx),
    .w_lo_mask (w_lo_mask),
    .w_hi_en   (w_hi_en),
    .rdata     (rdata)
);

// File: tb/mwr_ram_bench.sv
`timescale 1ns/1ps
module mwr_ram_bench;

    logic        clk = 1'b0;
    logic        wen = 1'b0, ren = 1'b0, rrst_n = 1'b0;
    logic [2:0]  wr_shape = 3'd0, rd_shape = 3'd0;
    logic [11:0] waddr = '0, raddr = '0;
    logic [17:0] wdata = '0;
    logic [17:0] rdata;

    int vectors = 0, fails = 0;
    bit done = 1'b0;
    logic [17:0] exp_q = '0;

    bit dbit [4096];
    bit xbit [512];

    always #2.5 clk = ~clk;

    mwr_ram u_mwr_ram (
        .wclk(clk), .wen(wen), .wr_shape(wr_shape), .waddr(waddr), .wdata(wdata),
        .rclk(clk), .rrst_n(rrst_n), .ren(ren), .rd_shape(rd_shape),
        .raddr(raddr), .rdata(rdata)
    );

    // Model of the stored bits, built from R2, R3 and R4.
    function automatic logic [17:0] mdl_read(int s, logic [11:0] a);
        logic [17:0] r = '0;
        int k;
        if (s <= 2 || s > 4) begin
            int w = (s > 4) ? 1 : (1 << s);
            k = int'(a) % (4096 / w);
            for (int i = 0; i < w; i++) r[i] = dbit[k*w + i];
        end else if (s == 3) begin
            k = int'(a[8:0]);
            for (int i = 0; i < 8; i++) r[i] = dbit[8*k + i];
            r[8] = xbit[k];
        end else begin
            k = int'(a[7:0]);
            for (int h = 0; h < 2; h++) begin
                for (int i = 0; i < 8; i++) r[9*h + i] = dbit[8*(2*k + h) + i];
                r[9*h + 8] = xbit[2*k + h];
            end
        end
        return r;
    endfunction

    function automatic void mdl_write(int s, logic [11:0] a, logic [17:0] d);
        int k;
        if (s <= 2 || s > 4) begin
            int w = (s > 4) ? 1 : (1 << s);
            k = int'(a) % (4096 / w);
            for (int i = 0; i < w; i++) dbit[k*w + i] = d[i];
        end else if (s == 3) begin
            k = int'(a[8:0]);
            for (int i = 0; i < 8; i++) dbit[8*k + i] = d[i];
            xbit[k] = d[8];
        end else begin
            k = int'(a[7:0]);
            for (int h = 0; h < 2; h++) begin
                for (int i = 0; i < 8; i++) dbit[8*(2*k + h) + i] = d[9*h + i];
                xbit[2*k + h] = d[9*h + 8];
            end
        end
    endfunction

    task automatic check(input string tag, input logic [17:0] got, input logic [17:0] want);
        vectors++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s: rdata=%h expected=%h at %0t", tag, got, want, $time);
        end
    endtask

    // One cycle: drive at a falling edge, compare at the next falling edge.
    task automatic step(input bit we, input logic [11:0] wa, input logic [17:0] wd,
                        input bit re, input logic [11:0] ra, input string tag);
        if (re) exp_q = mdl_read(int'(rd_shape), ra);   // old contents first (R9)
        if (we) mdl_write(int'(wr_shape), wa, wd);
        wen = we; waddr = wa; wdata = wd; ren = re; raddr = ra;
        @(negedge clk);
        check(tag, rdata, exp_q);
    endtask

    task automatic set_shapes(input logic [2:0] ws, input logic [2:0] rs);
        wen = 1'b0; ren = 1'b0; wr_shape = ws; rd_shape = rs;
        @(negedge clk);
        check("R7 shape change hold", rdata, exp_q);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R11 reset", rdata, 18'h0);
        rrst_n = 1'b1;
        @(negedge clk);
        check("R11 after release", rdata, 18'h0);

        // clear the whole array through the 18-bit shape
        set_shapes(3'd4, 3'd4);
        for (int a = 0; a < 256; a++) step(1, 12'(a), 18'h0, 0, 0, "R7 clear");

        // R6: write then read at full width, one cycle latency
        step(1, 12'd7, 18'h2B4C3, 0, 0, "R7");
        step(0, 0, 0, 1, 12'd7, "R6 read x18");
        check("R6 literal", rdata, 18'h2B4C3);

        // R8: disabled write leaves contents
        step(0, 12'd7, 18'h3FFFF, 0, 0, "R8 disabled write");
        step(0, 0, 0, 1, 12'd7, "R8 readback");
        check("R8 literal", rdata, 18'h2B4C3);

        // R4: 18-bit word 7 seen as 9-bit words 14 and 15
        set_shapes(3'd4, 3'd3);
        step(0, 0, 0, 1, 12'd14, "R4 low half");
        check("R4 low literal", rdata, 18'h0C3);
        step(0, 0, 0, 1, 12'd15, "R4 high half");
        check("R4 high literal", rdata, 18'h15A);

        // R2/R5: 4-bit write read as 1-bit stream
        set_shapes(3'd2, 3'd0);
        step(1, 12'd3, 18'h0000A, 0, 0, "R2 x4 write");
        for (int b = 12; b < 16; b++) begin
            step(0, 0, 0, 1, 12'(b), "R5 x4 to x1 stream");
            check("R2 stream literal", rdata, {17'b0, 1'(4'hA >> (b - 12))});
        end

        // R3: 9-bit word 5 at data bits 40..47 plus extra bit
        set_shapes(3'd3, 3'd0);
        step(1, 12'd5, 18'h1A5, 0, 0, "R3 x9 write");
        step(0, 0, 0, 1, 12'd40, "R3 bit 40");
        check("R3 bit 40 literal", rdata, 18'h1);
        set_shapes(3'd3, 3'd3);
        step(0, 0, 0, 1, 12'd5, "R3 readback");
        check("R3 literal", rdata, 18'h1A5);

        // R9: same-address read and write in one cycle returns old data
        step(1, 12'd5, 18'h0F0, 1, 12'd5, "R9 collision");
        check("R9 literal", rdata, 18'h1A5);
        step(0, 0, 0, 1, 12'd5, "R6 new data");

        // R7: hold with enable low while a read address changes
        step(0, 0, 0, 0, 12'd99, "R7 hold");

        // R10: upper address bits ignored, upper data bits zero
        set_shapes(3'd2, 3'd2);
        step(1, 12'h3FF, 18'h3FFF9, 0, 0, "R10 x4 write");
        step(0, 0, 0, 1, 12'hBFF, "R10 alias address");
        check("R10 literal", rdata, 18'h00009);

        // R1/R5: random traffic over every pair of shapes
        for (int ws = 0; ws < 5; ws++) begin
            for (int rs = 0; rs < 5; rs++) begin
                set_shapes(3'(ws), 3'(rs));
                for (int n = 0; n < 80; n++) begin
                    bit we = 1'($urandom_range(0, 1));
                    bit re = 1'($urandom_range(0, 3) != 0);
                    logic [11:0] wa = 12'($urandom);
                    logic [11:0] ra = (n % 4 == 0) ? wa : 12'($urandom);
                    step(we, wa, 18'($urandom), re, ra,
                         re ? "R1 R5 random shaped read" : "R7 random hold");
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run incomplete, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule